// File: doc/BRIEF.md
# Deferred Read Request Tracker

This block is the target-side front end of a bus bridge that never completes a read on its first attempt. When an initiator starts a read, the block records the address and bus command from the address phase, records the byte enables on the first cycle the initiator signals ready, stores the request in its single deferred-request entry, and ends the attempt with a retry. The stored request is offered to the far side of the bridge on a request port that holds its fields steady until they are acknowledged.

Completion data for the entry comes back as a stream of words. The stream ends with a word that carries a last flag. While the data is still arriving, every read attempt gets another retry. Once the stream is complete, the first repeat whose address, command and byte enables all equal the stored ones receives the words in order, one word per initiator-ready cycle. The final stored word goes out together with a disconnect. If the initiator ends the burst before the queue is empty, the rest of the words are thrown away. In both cases the entry becomes free again. An even-parity check over the address and command is reported on a separate error output.

Top module: `drt_tracker`

## Requirements
- R1: After reset `trdy_o`, `stop_o`, `req_valid_o` and `par_err_o` are low and the entry is free.
- R2: With the entry free, the first data phase of a read (commands 4'b0010, 4'b0110, 4'b1010, 4'b1100, 4'b1110) is answered with retry (`stop_o`=1, `trdy_o`=0). From the following cycle `req_valid_o` is high and carries the address and command from the address phase and the byte enables from that first data phase.
- R3: Once raised, `req_valid_o` and its address, command and byte-enable fields stay unchanged until a cycle with `req_ack_i` high. `req_valid_o` is low from the cycle after that acknowledgement.
- R4: While completion data is awaited, every read attempt gets retry. A differing read neither replaces the stored entry nor raises `req_valid_o` again.
- R5: Completion words are queued only while data is awaited. The word flagged last ends the wait. Words offered at any other time are dropped.
- R6: When the data is complete, a repeat that matches in address, command and byte enables is given `trdy_o` with the queued words on `data_o`, in arrival order, one word per data phase.
- R7: When the data is complete, a read that differs in address, command or byte enables gets retry, and the stored entry and its data are kept.
- R8: The last queued word is transferred with `stop_o` and `trdy_o` both high. The entry is then free, so the next read gets retry and a new request.
- R9: If the initiator's final data phase (`frame_i` low) transfers a word while more words remain, the remaining words are discarded and the entry becomes free.
- R10: `par_err_o` is high in the cycle after an address phase exactly when the XOR of address, command and `par_i` is 1.
- R11: Commands that are not reads receive neither `trdy_o` nor `stop_o` and are never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Initiator transaction active (high = asserted) |
| irdy_i | input | 1 | Initiator ready for a data phase |
| cmd_i | input | 4 | Bus command, sampled at the address phase |
| ad_i | input | AW | Address, sampled at the address phase |
| par_i | input | 1 | Even parity bit over address and command |
| be_i | input | BEW | Byte enables, sampled at the first data phase |
| trdy_o | output | 1 | Target ready: a data word is transferred |
| stop_o | output | 1 | Target termination: retry without `trdy_o`, disconnect with it |
| data_o | output | DW | Read data, valid with `trdy_o` |
| par_err_o | output | 1 | Address-phase parity mismatch, one cycle |
| req_valid_o | output | 1 | Stored request offered to the far bus |
| req_addr_o | output | AW | Stored request address |
| req_cmd_o | output | 4 | Stored request command |
| req_be_o | output | BEW | Stored request byte enables |
| req_ack_i | input | 1 | Far bus accepted the request |
| cpl_valid_i | input | 1 | Completion word valid |
| cpl_data_i | input | DW | Completion word |
| cpl_last_i | input | 1 | Final completion word for the entry |

## Verification
The bench aims at the boundaries between the entry's phases. A read that arrives while only part of the completion has come back must get retry; a design that releases data on the first word would hand out a short burst. Repeats that differ in exactly one of address, command or byte enables must get retry; a comparator that skips a field would deliver another initiator's data. An initiator that stops after two of five words must leave the entry free, and completion words sent while the entry is free must not show up in the next delivery; a design that keeps leftovers would return stale words in front of the fresh ones.

// File: rtl/drt_pkg.sv
package drt_pkg;

   localparam int CMD_W = 4;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PENDING = 2'd1,
      ST_READY   = 2'd2,
      ST_DELIVER = 2'd3
   } drt_state_e;

   localparam logic [CMD_W-1:0] CMD_IO_RD       = 4'b0010;
   localparam logic [CMD_W-1:0] CMD_MEM_RD      = 4'b0110;
   localparam logic [CMD_W-1:0] CMD_CFG_RD      = 4'b1010;
   localparam logic [CMD_W-1:0] CMD_MEM_RD_MULT = 4'b1100;
   localparam logic [CMD_W-1:0] CMD_MEM_RD_LINE = 4'b1110;

   function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
      return (c == CMD_IO_RD) || (c == CMD_MEM_RD) || (c == CMD_CFG_RD) ||
             (c == CMD_MEM_RD_MULT) || (c == CMD_MEM_RD_LINE);
   endfunction

endpackage

// File: rtl/drt_addr_capture.sv
module drt_addr_capture
   import drt_pkg::*;
#(
   parameter int AW        = 32,
   parameter bit PAR_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_i,
   input  logic             irdy_i,
   input  logic [AW-1:0]    ad_i,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic             par_i,
   input  logic             term_i,
   output logic             in_txn_o,
   output logic             first_dp_o,
   output logic             data_phase_o,
   output logic [AW-1:0]    cur_addr_o,
   output logic [CMD_W-1:0] cur_cmd_o,
   output logic             par_err_o
);

   logic frame_q;
   logic addr_phase;

   assign addr_phase   = frame_i & ~frame_q & ~in_txn_o;
   assign data_phase_o = in_txn_o & irdy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q    <= 1'b0;
         in_txn_o   <= 1'b0;
         first_dp_o <= 1'b0;
         cur_addr_o <= '0;
         cur_cmd_o  <= '0;
      end else begin
         frame_q <= frame_i;
         if (addr_phase) begin
            in_txn_o   <= 1'b1;
            first_dp_o <= 1'b1;
            cur_addr_o <= ad_i;
            cur_cmd_o  <= cmd_i;
         end else if (data_phase_o) begin
            first_dp_o <= 1'b0;
            if (term_i || !frame_i) in_txn_o <= 1'b0;
         end
      end
   end

   generate
      if (PAR_CHECK) begin : g_par
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) par_err_o <= 1'b0;
            else        par_err_o <= addr_phase & (^{ad_i, cmd_i, par_i});
         end
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = par_i;
         assign par_err_o  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/drt_entry_match.sv
module drt_entry_match
   import drt_pkg::*;
#(
   parameter int AW       = 32,
   parameter int BEW      = 4,
   parameter bit MATCH_BE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic [BEW-1:0]   be_i,
   output logic             match_o,
   output logic [AW-1:0]    ent_addr_o,
   output logic [CMD_W-1:0] ent_cmd_o,
   output logic [BEW-1:0]   ent_be_o
);

   logic addr_eq, cmd_eq, be_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_addr_o <= '0;
         ent_cmd_o  <= '0;
         ent_be_o   <= '0;
      end else if (load_i) begin
         ent_addr_o <= addr_i;
         ent_cmd_o  <= cmd_i;
         ent_be_o   <= be_i;
      end
   end

   assign addr_eq = (addr_i == ent_addr_o);
   assign cmd_eq  = (cmd_i == ent_cmd_o);

   generate
      if (MATCH_BE) begin : g_be_cmp
         assign be_eq = (be_i == ent_be_o);
      end else begin : g_be_skip
         assign be_eq = 1'b1;
      end
   endgenerate

   assign match_o = addr_eq & cmd_eq & be_eq;

endmodule

// File: rtl/drt_data_queue.sv
module drt_data_queue #(
   parameter int DW    = 32,
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [DW-1:0]    push_data_i,
   input  logic             pop_i,
   input  logic             flush_i,
   output logic [DW-1:0]    head_o,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("drt_data_queue: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full_o  = (count_o == CNT_W'(DEPTH));
   assign do_push = push_i & ~full_o & ~flush_i;
   assign do_pop  = pop_i & (count_o != '0) & ~flush_i;
   assign head_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_o <= '0;
      end else if (flush_i) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_o <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count_o <= count_o + 1'b1;
            2'b01:   count_o <= count_o - 1'b1;
            default: count_o <= count_o;
         endcase
      end
   end

endmodule

// File: rtl/drt_tracker.sv
module drt_tracker
   import drt_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int BEW       = 4,
   parameter int DEPTH     = 16,
   parameter bit PAR_CHECK = 1'b1,
   parameter bit MATCH_BE  = 1'b1,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_i,
   input  logic             irdy_i,
   input  logic [3:0]       cmd_i,
   input  logic [AW-1:0]    ad_i,
   input  logic             par_i,
   input  logic [BEW-1:0]   be_i,
   output logic             trdy_o,
   output logic             stop_o,
   output logic [DW-1:0]    data_o,
   output logic             par_err_o,
   output logic             req_valid_o,
   output logic [AW-1:0]    req_addr_o,
   output logic [3:0]       req_cmd_o,
   output logic [BEW-1:0]   req_be_o,
   input  logic             req_ack_i,
   input  logic             cpl_valid_i,
   input  logic [DW-1:0]    cpl_data_i,
   input  logic             cpl_last_i
);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("drt_tracker: AW must be at least 2");
      end
      if (DW < 1 || BEW < 1) begin : g_bad_dw
         $error("drt_tracker: DW and BEW must be positive");
      end
   endgenerate

   drt_state_e        state, state_d;
   logic              in_txn, first_dp, dp, first_rd;
   logic [AW-1:0]     cur_addr;
   logic [CMD_W-1:0]  cur_cmd;
   logic              match;
   logic              load, req_set;
   logic              push, pop, flush;
   logic [DW-1:0]     q_head;
   logic [CNT_W-1:0]  q_cnt;
   logic              q_full;

   drt_addr_capture #(.AW(AW), .PAR_CHECK(PAR_CHECK)) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_i      (frame_i),
      .irdy_i       (irdy_i),
      .ad_i         (ad_i),
      .cmd_i        (cmd_i),
      .par_i        (par_i),
      .term_i       (stop_o),
      .in_txn_o     (in_txn),
      .first_dp_o   (first_dp),
      .data_phase_o (dp),
      .cur_addr_o   (cur_addr),
      .cur_cmd_o    (cur_cmd),
      .par_err_o    (par_err_o)
   );

   drt_entry_match #(.AW(AW), .BEW(BEW), .MATCH_BE(MATCH_BE)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .addr_i     (cur_addr),
      .cmd_i      (cur_cmd),
      .be_i       (be_i),
      .match_o    (match),
      .ent_addr_o (req_addr_o),
      .ent_cmd_o  (req_cmd_o),
      .ent_be_o   (req_be_o)
   );

   drt_data_queue #(.DW(DW), .DEPTH(DEPTH)) u_q (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_data_i (cpl_data_i),
      .pop_i       (pop),
      .flush_i     (flush),
      .head_o      (q_head),
      .count_o     (q_cnt),
      .full_o      (q_full)
   );

   assign first_rd = dp & first_dp & cmd_is_read(cur_cmd);
   assign push     = cpl_valid_i & (state == ST_PENDING) & ~q_full;
   assign data_o   = trdy_o ? q_head : '0;

   always_comb begin
      state_d = state;
      trdy_o  = 1'b0;
      stop_o  = 1'b0;
      load    = 1'b0;
      req_set = 1'b0;
      pop     = 1'b0;
      flush   = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (first_rd) begin
               stop_o  = 1'b1;
               load    = 1'b1;
               req_set = 1'b1;
               state_d = ST_PENDING;
            end
         end
         ST_PENDING: begin
            if (first_rd) stop_o = 1'b1;
            if (cpl_valid_i && cpl_last_i) state_d = ST_READY;
         end
         ST_READY: begin
            if (first_rd) begin
               if (match) begin
                  trdy_o = 1'b1;
                  pop    = 1'b1;
                  if (q_cnt == CNT_W'(1)) begin
                     stop_o  = 1'b1;
                     state_d = ST_IDLE;
                  end else if (!frame_i) begin
                     flush   = 1'b1;
                     state_d = ST_IDLE;
                  end else begin
                     state_d = ST_DELIVER;
                  end
               end else begin
                  stop_o = 1'b1;
               end
            end
         end
         ST_DELIVER: begin
            if (dp) begin
               trdy_o = 1'b1;
               pop    = 1'b1;
               if (q_cnt == CNT_W'(1)) begin
                  stop_o  = 1'b1;
                  state_d = ST_IDLE;
               end else if (!frame_i) begin
                  flush   = 1'b1;
                  state_d = ST_IDLE;
               end
            end else if (!in_txn) begin
               flush   = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         req_valid_o <= 1'b0;
      end else begin
         state <= state_d;
         if (req_set)        req_valid_o <= 1'b1;
         else if (req_ack_i) req_valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/drt_tracker_chk.sv
module drt_tracker_chk
   import drt_pkg::*;
#(
   parameter int AW    = 32,
   parameter int BEW   = 4,
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input drt_state_e       state,
   input logic             trdy_o,
   input logic             stop_o,
   input logic             frame_i,
   input logic             par_err_o,
   input logic             req_valid_o,
   input logic             req_ack_i,
   input logic [AW-1:0]    req_addr_o,
   input logic [3:0]       req_cmd_o,
   input logic [BEW-1:0]   req_be_o,
   input logic [CNT_W-1:0] q_cnt
);

   // R2
   retry_posts_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && stop_o && !trdy_o) |=> (state == ST_PENDING && req_valid_o));

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ack_i) |=>
         (req_valid_o && $stable(req_addr_o) && $stable(req_cmd_o) && $stable(req_be_o)));

   // R6
   data_only_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trdy_o |-> (state == ST_READY || state == ST_DELIVER));

   // R7
   mismatch_keeps_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READY && stop_o && !trdy_o) |=> (state == ST_READY && $stable(q_cnt)));

   // R8
   disconnect_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trdy_o && stop_o) |=> (state == ST_IDLE && q_cnt == '0));

   // R10
   par_err_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_err_o |-> $past(frame_i));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt <= CNT_W'(DEPTH));

endmodule

bind drt_tracker drt_tracker_chk #(.AW(AW), .BEW(BEW), .DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .state       (state),
   .trdy_o      (trdy_o),
   .stop_o      (stop_o),
   .frame_i     (frame_i),
   .par_err_o   (par_err_o),
   .req_valid_o (req_valid_o),
   .req_ack_i   (req_ack_i),
   .req_addr_o  (req_addr_o),
   .req_cmd_o   (req_cmd_o),
   .req_be_o    (req_be_o),
   .q_cnt       (q_cnt)
);

// File: tb/drt_tracker_tb.sv
module drt_tracker_tb;

   localparam int AW = 32, DW = 32, BEW = 4, DEPTH = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic frame = 0, irdy = 0, par = 0;
   logic [3:0] cmd = '0;
   logic [AW-1:0] ad = '0;
   logic [BEW-1:0] be = '0;
   logic trdy_o, stop_o, par_err_o, req_valid_o;
   logic [DW-1:0] data_o;
   logic [AW-1:0] req_addr_o;
   logic [3:0] req_cmd_o;
   logic [BEW-1:0] req_be_o;
   logic req_ack = 0, cpl_valid = 0, cpl_last = 0;
   logic [DW-1:0] cpl_data = '0;

   always #5 clk = ~clk;

   drt_tracker #(.AW(AW), .DW(DW), .BEW(BEW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_i(frame), .irdy_i(irdy), .cmd_i(cmd),
      .ad_i(ad), .par_i(par), .be_i(be), .trdy_o(trdy_o), .stop_o(stop_o),
      .data_o(data_o), .par_err_o(par_err_o), .req_valid_o(req_valid_o),
      .req_addr_o(req_addr_o), .req_cmd_o(req_cmd_o), .req_be_o(req_be_o),
      .req_ack_i(req_ack), .cpl_valid_i(cpl_valid), .cpl_data_i(cpl_data),
      .cpl_last_i(cpl_last)
   );

   typedef struct { logic [DW-1:0] d; bit disc; } exp_t;
   exp_t sb_q[$];

   int checks = 0, errors = 0;
   int r_got;
   bit r_retry, r_disc, r_perr;

   localparam logic [3:0] MRD = 4'b0110, MRL = 4'b1110, CRD = 4'b1010, MWR = 4'b0111;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // driver: one initiator transaction of up to maxw data phases
   task automatic bus_txn(input logic [AW-1:0] a, input logic [3:0] c,
                          input logic [BEW-1:0] b, input bit badpar, input int maxw);
      r_got = 0; r_retry = 0; r_disc = 0; r_perr = 0;
      @(negedge clk);
      frame = 1; irdy = 0; ad = a; cmd = c; par = (^{a, c}) ^ badpar;
      for (int i = 0; i < maxw; i++) begin
         @(negedge clk);
         irdy = 1; be = b; frame = (i < maxw - 1);
         #2;
         if (i == 0) r_perr = par_err_o;
         if (stop_o && !trdy_o) begin r_retry = 1; break; end
         if (trdy_o) r_got++;
         if (stop_o && trdy_o) begin r_disc = 1; break; end
      end
      @(negedge clk);
      frame = 0; irdy = 0;
   endtask

   task automatic expect_words(input logic [DW-1:0] base, input int n, input bit disc_last);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.d = base + DW'(i);
         e.disc = disc_last && (i == n - 1);
         sb_q.push_back(e);
      end
   endtask

   task automatic send_cpl(input logic [DW-1:0] base, input int n, input bit with_last);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cpl_valid = 1; cpl_data = base + DW'(i); cpl_last = with_last && (i == n - 1);
      end
      @(negedge clk);
      cpl_valid = 0; cpl_last = 0;
   endtask

   task automatic ack_req;
      @(negedge clk); req_ack = 1;
      @(negedge clk); req_ack = 0;
   endtask

   task automatic check_req(input string req, input logic [AW-1:0] a,
                            input logic [3:0] c, input logic [BEW-1:0] b);
      #2;
      check(req_valid_o == 1'b1, req, "req_valid", req_valid_o, 1);
      check(req_addr_o == a, req, "req_addr", req_addr_o, a);
      check(req_cmd_o == c, req, "req_cmd", req_cmd_o, c);
      check(req_be_o == b, req, "req_be", req_be_o, b);
   endtask

   // monitor: compares each transferred word with the scoreboard
   always @(negedge clk) begin
      #2;
      if (rst_n && trdy_o) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R6", "unexpected data word", data_o, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(data_o == e.d, "R6", "data word", data_o, e.d);
            check(stop_o == e.disc, "R8", "disconnect flag", stop_o, e.disc);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      check(trdy_o == 0 && stop_o == 0, "R1", "trdy/stop in reset", {trdy_o, stop_o}, 0);
      check(req_valid_o == 0 && par_err_o == 0, "R1", "req/par in reset",
            {req_valid_o, par_err_o}, 0);
      @(negedge clk); rst_n = 1;

      // R2 first attempt retried and forwarded
      bus_txn(32'h0000_1000, MRD, 4'hF, 0, 4);
      check(r_retry == 1 && r_got == 0, "R2", "first attempt retry", r_got, 0);
      check(r_perr == 0, "R10", "no parity error on good parity", r_perr, 0);
      check_req("R2", 32'h0000_1000, MRD, 4'hF);
      // R3 held until acknowledged
      repeat (2) @(negedge clk);
      check_req("R3", 32'h0000_1000, MRD, 4'hF);
      ack_req();
      #2;
      check(req_valid_o == 0, "R3", "req drops after ack", req_valid_o, 0);

      // R4 pending: same and different reads retried, nothing re-forwarded
      bus_txn(32'h0000_1000, MRD, 4'hF, 0, 4);
      check(r_retry == 1 && r_got == 0, "R4", "repeat while pending", r_got, 0);
      bus_txn(32'h0000_2000, MRL, 4'h1, 0, 2);
      check(r_retry == 1, "R4", "other read while pending", r_retry, 1);
      #2;
      check(req_valid_o == 0, "R4", "no new request while pending", req_valid_o, 0);

      // R5 partial completion keeps the entry waiting
      send_cpl(32'hA000_0000, 2, 0);
      bus_txn(32'h0000_1000, MRD, 4'hF, 0, 4);
      check(r_retry == 1 && r_got == 0, "R5", "partial data still retried", r_got, 0);
      send_cpl(32'hA000_0002, 2, 1);

      // R7 mismatch in each field
      bus_txn(32'h0000_1000, MRD, 4'h3, 0, 4);
      check(r_retry == 1, "R7", "be mismatch retry", r_retry, 1);
      bus_txn(32'h0000_1004, MRD, 4'hF, 0, 4);
      check(r_retry == 1, "R7", "addr mismatch retry", r_retry, 1);
      bus_txn(32'h0000_1000, MRL, 4'hF, 0, 4);
      check(r_retry == 1, "R7", "cmd mismatch retry", r_retry, 1);

      // R6 R8 full delivery with disconnect on the last word
      expect_words(32'hA000_0000, 4, 1);
      bus_txn(32'h0000_1000, MRD, 4'hF, 0, 8);
      check(r_got == 4 && r_disc == 1, "R8", "words then disconnect", r_got, 4);

      // R8 entry free: new read retried and forwarded
      bus_txn(32'h0000_3000, CRD, 4'h5, 0, 3);
      check(r_retry == 1, "R8", "next read retried", r_retry, 1);
      check_req("R8", 32'h0000_3000, CRD, 4'h5);
      ack_req();
      send_cpl(32'hC000_0000, 5, 1);

      // R9 early end by initiator after two words
      expect_words(32'hC000_0000, 2, 0);
      bus_txn(32'h0000_3000, CRD, 4'h5, 0, 2);
      check(r_got == 2 && r_disc == 0, "R9", "early end transfers two", r_got, 2);

      // R5 completions while free are dropped; R11 write ignored
      send_cpl(32'hEEEE_0000, 3, 1);
      bus_txn(32'h0000_4000, MWR, 4'hF, 0, 1);
      check(r_retry == 0 && r_got == 0, "R11", "write gets no response", r_retry, 0);
      #2;
      check(req_valid_o == 0, "R11", "write not forwarded", req_valid_o, 0);

      // R9 R10 fresh request after discard, with bad parity
      bus_txn(32'h0000_3000, CRD, 4'h5, 1, 2);
      check(r_retry == 1, "R9", "discarded entry: fresh retry", r_retry, 1);
      check(r_perr == 1, "R10", "parity error flagged", r_perr, 1);
      check_req("R9", 32'h0000_3000, CRD, 4'h5);
      ack_req();
      send_cpl(32'hD000_0000, 2, 1);
      expect_words(32'hD000_0000, 2, 1);
      bus_txn(32'h0000_3000, CRD, 4'h5, 0, 4);
      check(r_got == 2 && r_disc == 1, "R5", "only fresh words delivered", r_got, 2);

      repeat (2) @(negedge clk);
      check(sb_q.size() == 0, "R6", "all expected words seen", sb_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule